// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host perform single-byte reads and writes on an asynchronous 128K x 8 static RAM. The host offers a request through a valid/ready handshake with a 17-bit address, an 8-bit write byte and a write flag. The controller then plays out the strobe sequence the memory needs, and for reads it returns the byte with a one-cycle valid pulse.

On the memory side it drives a pair of chip selects of opposite polarity, an active-low output enable, an active-low write enable, and an 8-bit data bus. The bus is split into an outgoing byte, an incoming byte and a drive-enable, so that a pad ring or a bench can form the tri-state.

Every phase length is a whole number of clock cycles. Each is found by rounding a nanosecond limit up to the clock period. One parameter picks between the limits of the faster and the slower speed grade. With the defaults (5 ns clock, faster grade), a read holds the access phase for 14 cycles and then waits 5 turnaround cycles. A write holds the write-enable pulse for 12 cycles, keeps driving for one hold cycle, and then releases the bus for one recovery cycle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, req_ready_o is 1, mem_cs_n_o is 1, mem_cs_o is 0, mem_oe_n_o is 1, mem_we_n_o is 1, mem_dq_oe_o is 0 and rd_valid_o is 0.
- R2: The memory counts as selected only when mem_cs_n_o is 0 and mem_cs_o is 1. Both chip selects take that state together for the access phase of every read and write, and both return to the deselected pair (1 and 0) outside it.
- R3: A read accepted in cycle t keeps the memory selected, with mem_oe_n_o at 0 and mem_we_n_o at 1, for cycles t+1 to t+14. The byte on mem_dq_i is sampled at the end of cycle t+14. rd_data_o then carries that byte, and rd_valid_o is 1, for exactly one cycle: t+15.
- R4: A write accepted in cycle t holds mem_we_n_o at 0 with the memory selected and mem_oe_n_o at 1 for 12 cycles (at least 11, which covers 55 ns). The stored byte is driven on mem_dq_o with mem_dq_oe_o at 1 and stays stable through the whole pulse, so it is valid for at least 6 cycles before the end of the write. Driving continues for one further cycle after mem_we_n_o rises.
- R5: mem_dq_oe_o is never 1 while mem_oe_n_o is 0. mem_dq_oe_o is 0 in the cycle before mem_oe_n_o falls. After the last cycle with mem_oe_n_o at 0, at least 5 cycles pass before mem_dq_oe_o rises again.
- R6: req_ready_o is 0 from the cycle after an accept until the cycle is complete: 19 cycles for a read and 14 cycles for a write. A request is accepted only in a cycle where req_valid_i and req_ready_o are both 1.
- R7: A request held on req_valid_i while req_ready_o is 0, and withdrawn before req_ready_o returns, has no effect on memory contents.
- R8: The address and write byte are captured at accept. mem_addr_o and the driven byte stay stable for the whole cycle even if the host inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller idle, request may be taken |
| req_we_i | input | 1 | 1 = write request, 0 = read request |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rd_data_o | output | 8 | Read byte |
| rd_valid_o | output | 1 | One-cycle pulse, rd_data_o valid |
| mem_addr_o | output | 17 | Memory address lines |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_cs_o | output | 1 | Chip select, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Byte driven towards the memory |
| mem_dq_oe_o | output | 1 | Drive-enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte returned by the memory |

## Verification
The assertions assume the host never changes a request's fields except while req_ready_o is 0 or after the request has been taken. They also assume the memory supplies a byte only on mem_dq_i and never contends with the controller's drive. The bench holds its request steady until a negative edge shows req_ready_o high. Its memory model returns a defined byte only after the address and select have been held for 14 cycles; at any other time it returns unknowns. The bench deliberately leaves req_valid_i asserted with altered fields during busy cycles. This exercises R7 and R8 while staying inside these assumptions, because the request is always withdrawn before ready returns.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACC, ST_RD_TURN, ST_WR_PULSE, ST_WR_HOLD, ST_WR_REC
  } state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_io_path.sv
`timescale 1ns/1ps
module sram_io_path #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              drive_nxt_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      dq_o     <= '0;
      dq_oe_o  <= 1'b0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      if (accept_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      dq_oe_o  <= drive_nxt_i;
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= dq_i;
    end
  end

  // R4: driven byte never changes while the drive stays on
  p_dq_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o)) |-> $stable(dq_o))
    else $error("driven byte changed during write");

  // R3: read-valid is a single-cycle pulse
  p_rvalid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o)
    else $error("read valid longer than one cycle");
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 5,
  parameter bit          SLOW_GRADE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_cs_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  // limits in ns per speed grade
  localparam int unsigned T_RC_NS = SLOW_GRADE ? 100 : 70;
  localparam int unsigned T_AA_NS = SLOW_GRADE ? 100 : 70;
  localparam int unsigned T_OE_NS = SLOW_GRADE ? 50  : 35;
  localparam int unsigned T_WC_NS = SLOW_GRADE ? 100 : 70;
  localparam int unsigned T_WP_NS = SLOW_GRADE ? 70  : 55;
  localparam int unsigned T_CW_NS = SLOW_GRADE ? 80  : 60;
  localparam int unsigned T_DW_NS = SLOW_GRADE ? 40  : 30;
  localparam int unsigned T_HZ_NS = SLOW_GRADE ? 30  : 25;

  localparam int unsigned RD_CYC = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                        ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned WP_CYC = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                                        ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int unsigned WC_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned REC_CYC  = (WC_CYC > WP_CYC + 2) ? WC_CYC - WP_CYC - 1 : 1;
  localparam int unsigned TURN_CYC = max2(ns_to_cyc(T_HZ_NS, CLK_NS), 1);
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(REC_CYC, TURN_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  state_e           state_q, state_d;
  logic             load, done, accept, capture, drive_nxt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept = 1'b1;
        load   = 1'b1;
        if (req_we_i) begin
          state_d  = ST_WR_PULSE;
          load_val = CNT_W'(WP_CYC - 1);
        end else begin
          state_d  = ST_RD_ACC;
          load_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD_ACC: if (done) begin
        capture  = 1'b1;
        state_d  = ST_RD_TURN;
        load     = 1'b1;
        load_val = CNT_W'(TURN_CYC - 1);
      end
      ST_RD_TURN:  if (done) state_d = ST_IDLE;
      ST_WR_PULSE: if (done) state_d = ST_WR_HOLD;
      ST_WR_HOLD: begin
        state_d  = ST_WR_REC;
        load     = 1'b1;
        load_val = CNT_W'(REC_CYC - 1);
      end
      ST_WR_REC:   if (done) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // drive covers the pulse plus one hold cycle
  assign drive_nxt   = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_cs_o    = (state_q == ST_RD_ACC) || (state_q == ST_WR_PULSE);
  assign mem_cs_n_o  = !mem_cs_o;
  assign mem_oe_n_o  = (state_q != ST_RD_ACC);
  assign mem_we_n_o  = (state_q != ST_WR_PULSE);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_io_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .drive_nxt_i (drive_nxt),
    .capture_i   (capture),
    .dq_i        (mem_dq_i),
    .addr_o      (mem_addr_o),
    .dq_o        (mem_dq_o),
    .dq_oe_o     (mem_dq_oe_o),
    .rdata_o     (rd_data_o),
    .rvalid_o    (rd_valid_o)
  );

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o)
    else $error("bus driven while output enable low");

  p_turnaround_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o))
    else $error("no release cycle before output enable");

  p_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o)
    else $error("ready high right after accept");

  p_write_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_dq_oe_o && mem_oe_n_o && !mem_cs_n_o))
    else $error("write strobe without drive or select");

  p_addr_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(mem_addr_o))
    else $error("address moved during a cycle");
endmodule

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, ready, we;
  logic [16:0] addr;
  logic [7:0]  wdata, rd_data;
  logic        rd_valid;
  logic [16:0] mem_addr;
  logic        cs_n, cs, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o, dq_in;

  always #2.5 clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .mem_addr_o(mem_addr),
    .mem_cs_n_o(cs_n), .mem_cs_o(cs), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_in)
  );

  int  checks = 0, fails = 0, cyc = 0;
  bit  finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // memory model
  logic [7:0]  mem [logic [16:0]];
  logic [7:0]  exp_mem [logic [16:0]];
  int          rd_age = 0, wp = 0, dw = 0, since_oe = 100;
  bit          wr_act = 0, prev_oe_n = 1, prev_dq_oe = 0, prev_rv = 0;
  logic [16:0] last_addr = '0, w_addr = '0;
  logic [7:0]  last_dq = '0;

  initial dq_in = 'x;

  always @(negedge clk) if (rst_n) begin
    if (!cs_n && cs && !oe_n && we_n)
      rd_age = (rd_age > 0 && mem_addr != last_addr) ? 1 : rd_age + 1;
    else
      rd_age = 0;
    last_addr = mem_addr;
    dq_in = (rd_age >= 14 && mem.exists(mem_addr)) ? mem[mem_addr] : 'x;

    if (!cs_n && cs && !we_n) begin
      if (!wr_act) begin wr_act = 1; wp = 0; dw = 0; w_addr = mem_addr; end
      wp++;
      if (dq_oe && dw > 0 && dq_o === last_dq) dw++;
      else dw = dq_oe ? 1 : 0;
      last_dq = dq_o;
    end else if (wr_act) begin
      wr_act = 0;
      chk(wp >= 11, "R4", "write pulse cycles", wp, 11);
      chk(dw >= 6, "R4", "data valid before end", dw, 6);
      chk(dq_oe && dq_o === last_dq, "R4", "data held after end", dq_o, last_dq);
      mem[w_addr] = last_dq;
    end

    if (prev_oe_n && !oe_n)
      chk(!prev_dq_oe && !dq_oe, "R5", "release before output enable", {prev_dq_oe, dq_oe}, 0);
    if (dq_oe && !prev_dq_oe)
      chk(since_oe >= 5, "R5", "turnaround cycles", since_oe, 5);
    if (!oe_n) since_oe = 0; else if (since_oe < 100) since_oe++;
    prev_oe_n  = oe_n;
    prev_dq_oe = dq_oe;
  end

  // scoreboard
  logic [7:0] exp_data [$];
  int         exp_cyc [$];
  string      exp_tag [$];

  always @(negedge clk) if (rst_n) begin
    if (rd_valid) begin
      if (exp_data.size() == 0) chk(0, "R3", "unexpected read valid", 1, 0);
      else begin
        logic [7:0] d; int c; string t;
        d = exp_data.pop_front(); c = exp_cyc.pop_front(); t = exp_tag.pop_front();
        chk(rd_data === d, t, "read data", rd_data, d);
        chk(cyc == c, "R3", "read valid cycle", cyc, c);
      end
      if (prev_rv) chk(0, "R3", "read valid pulse width", 2, 1);
    end
    prev_rv = rd_valid;
  end

  task automatic req(bit w, logic [16:0] a, logic [7:0] d, int noise, string tag);
    int c, n;
    @(negedge clk);
    valid = 1; we = w; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    c = cyc;
    @(negedge clk);
    chk(!ready, "R6", "ready after accept", ready, 0);
    chk(!cs_n && cs, "R2", "select pair active", {cs_n, cs}, 1);
    if (w) chk(!we_n && oe_n, "R4", "write strobes", {we_n, oe_n}, 1);
    else   chk(!oe_n && we_n, "R3", "read strobes", {oe_n, we_n}, 1);
    if (noise > 0) begin we = 1; addr = ~a; wdata = ~d; end
    else valid = 0;
    if (!w) begin
      exp_data.push_back(exp_mem[a]); exp_cyc.push_back(c + 15); exp_tag.push_back(tag);
    end else exp_mem[a] = d;
    n = 1;
    forever begin
      @(negedge clk);
      if (ready) break;
      n++;
      if (n > noise) valid = 0;
    end
    chk(n == (w ? 14 : 19), "R6", "busy cycles", n, w ? 14 : 19);
    chk(!cs_n == 1'b0 && cs == 1'b0, "R2", "deselected when idle", {cs_n, cs}, 2);
  endtask

  initial begin
    rst_n = 0; valid = 0; we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(ready && cs_n && !cs && oe_n && we_n && !dq_oe && !rd_valid, "R1", "reset outputs",
        {ready, cs_n, cs, oe_n, we_n, dq_oe, rd_valid}, 7'b1101100);
    rst_n = 1;
    @(negedge clk);
    chk(ready && cs_n && !cs && oe_n && we_n && !dq_oe && !rd_valid, "R1", "idle after reset",
        {ready, cs_n, cs, oe_n, we_n, dq_oe, rd_valid}, 7'b1101100);

    req(1, 17'h00000, 8'hA5, 0, "R4");
    req(1, 17'h1FFFF, 8'h5A, 0, "R4");
    req(1, 17'h12345, 8'hFF, 0, "R4");
    req(1, 17'h0DCBA, 8'h00, 0, "R4");
    req(1, 17'h1FFFE, 8'h77, 0, "R4");
    req(1, 17'h00001, 8'h3C, 0, "R4");
    req(0, 17'h00000, 8'h00, 0, "R3");
    req(0, 17'h1FFFF, 8'h00, 0, "R3");
    req(0, 17'h12345, 8'h00, 0, "R3");
    // busy-time noise targets the complement address (R7, R8)
    req(1, 17'h12345, 8'h81, 3, "R8");
    req(0, 17'h12345, 8'h00, 0, "R8");
    req(0, 17'h0DCBA, 8'h00, 0, "R7");
    req(0, 17'h00001, 8'h00, 3, "R7");
    req(0, 17'h1FFFE, 8'h00, 0, "R7");
    req(0, 17'h00001, 8'h00, 0, "R3");
    for (int i = 0; i < 8; i++) req(1, 17'(i * 17'h3001), 8'(i * 37 + 1), 0, "R4");
    for (int i = 7; i >= 0; i--) req(0, 17'(i * 17'h3001), 8'h00, 0, "R3");
    repeat (20) @(negedge clk);
    chk(exp_data.size() == 0, "R3", "reads outstanding", exp_data.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule